// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory for a small group of memory blocks in a shared-memory system of up to `NPROC` processors. For every block it holds a three-way sharing state (no holder, one or more readers, one owner with write rights) and a presence vector with one bit per processor. Because the vector names the holders, invalidations go only to the processors that actually hold a copy; nothing is broadcast.

Processors send read misses, write misses and write-backs, each tagged with the requester number and the block index. The directory answers with a data grant, an invalidate message to a set of sharers, or a fetch request to the current owner. While invalidations or an owner fetch are outstanding, the directory waits for one acknowledgement per targeted processor. During that time it stalls further requests, so all requests are serialized at the home node and every processor sees writes to a block in one order.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty vector, `req_ready` is 1 and `grant_valid`, `inv_valid` and `fetch_valid` are 0.
- R2: A read miss (`req_kind`=0) to an uncached or shared block adds the requester to the vector, leaves the block shared, and raises `grant_valid` with `grant_excl`=0 in the cycle after acceptance.
- R3: A write miss (`req_kind`=1) to a block that no other processor holds gives the requester sole ownership and raises `grant_valid` with `grant_excl`=1 in the cycle after acceptance, with no invalidate.
- R4: A write miss to a block that other processors hold raises `inv_valid` in the cycle after acceptance, with `inv_mask` bit i set for each holder i except the requester. The exclusive grant to the requester is withheld until every targeted processor has acknowledged, and it appears in the cycle after the last acknowledgement is sampled. Afterwards only the requester holds the block.
- R5: A read miss to a block owned exclusively by another processor raises `fetch_valid` to that owner in the cycle after acceptance. After the owner acknowledges, the requester receives a shared grant, and both the old owner and the requester are listed as holders.
- R6: A write-back (`req_kind`=2) from the exclusive owner returns the block to uncached with an empty vector.
- R7: A write-back from a processor that is not the exclusive owner, and any request with `req_kind`=3, leave the directory unchanged and produce no output.
- R8: From the cycle after a request that starts invalidations or a fetch until the cycle after its final acknowledgement, `req_ready` is 0 and no request is taken. An acknowledgement from a processor that is not awaited is ignored.
- R9: A read miss from the current exclusive owner returns an exclusive grant at once, with no fetch and no change of state.
- R10: Each block keeps its own state and vector; traffic to one block does not alter another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Directory can take a request this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 none |
| req_src | input | PIDW | Requesting processor |
| req_blk | input | BLKW | Target block |
| ack_valid | input | 1 | Acknowledgement of an invalidate or fetch |
| ack_src | input | PIDW | Processor sending the acknowledgement |
| inv_valid | output | 1 | Invalidate message valid (one cycle) |
| inv_mask | output | NPROC | Processors to invalidate |
| inv_blk | output | BLKW | Block to invalidate |
| fetch_valid | output | 1 | Owner fetch message valid (one cycle) |
| fetch_dst | output | PIDW | Owner asked to return the block |
| fetch_blk | output | BLKW | Block to fetch |
| grant_valid | output | 1 | Data grant valid (one cycle) |
| grant_dst | output | PIDW | Processor receiving the grant |
| grant_blk | output | BLKW | Block granted |
| grant_excl | output | 1 | 1 exclusive grant, 0 shared grant |

## Verification
The final acknowledgement that releases a stall and a new request waiting at the stalled input can fall in the same cycle. The bench provokes this by holding a read miss to the same block valid while it drives the last invalidation acknowledgement. It then judges that the exclusive grant appears first and `req_ready` rises in that same cycle. The waiting read is expected to be taken one cycle later, and because it now sees the new exclusive owner it must produce a fetch to that owner. A fetch addressed to the pre-write sharers, or a shared grant, is reported as a mismatch.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2,
    RQ_NONE  = 2'd3
  } rkind_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int NBLK  = 4,
  localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLKW-1:0]  rd_blk,
  output dstate_e          rd_state,
  output logic [NPROC-1:0] rd_vec,
  input  logic             we,
  input  logic [BLKW-1:0]  wr_blk,
  input  dstate_e          wr_state,
  input  logic [NPROC-1:0] wr_vec
);
  dstate_e          st_q  [NBLK];
  logic [NPROC-1:0] vec_q [NBLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i]  <= ST_UNC;
        vec_q[i] <= '0;
      end
    end else if (we) begin
      st_q[wr_blk]  <= wr_state;
      vec_q[wr_blk] <= wr_vec;
    end
  end

  assign rd_state = st_q[rd_blk];
  assign rd_vec   = vec_q[rd_blk];

  // R3
  excl_single_holder_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == ST_EXC) |-> ($countones(wr_vec) == 1));
  // R6
  unc_empty_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == ST_UNC) |-> (wr_vec == '0));
  // R2
  shr_has_holder_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_state == ST_SHR) |-> (wr_vec != '0));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NPROC = 8,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [1:0]       kind,
  input  logic [PIDW-1:0]  src,
  input  dstate_e          cur_st,
  input  logic [NPROC-1:0] cur_vec,
  output logic             upd,
  output dstate_e          nst,
  output logic [NPROC-1:0] nvec,
  output logic             grant,
  output logic             gexcl,
  output logic             inv,
  output logic [NPROC-1:0] inv_mask,
  output logic             fetch,
  output logic [PIDW-1:0]  owner
);
  logic [NPROC-1:0] sel;
  logic [NPROC-1:0] others;

  always_comb begin
    sel      = NPROC'(1) << src;
    others   = cur_vec & ~sel;
    owner    = '0;
    for (int i = 0; i < NPROC; i++)
      if (cur_vec[i]) owner = PIDW'(i);
    upd      = 1'b0;
    nst      = cur_st;
    nvec     = cur_vec;
    grant    = 1'b0;
    gexcl    = 1'b0;
    inv      = 1'b0;
    inv_mask = '0;
    fetch    = 1'b0;
    case (rkind_e'(kind))
      RQ_READ: begin
        if (cur_st == ST_EXC && others != '0) begin
          fetch = 1'b1;
        end else if (cur_st == ST_EXC) begin
          grant = 1'b1;
          gexcl = 1'b1;
        end else begin
          upd   = 1'b1;
          nst   = ST_SHR;
          nvec  = cur_vec | sel;
          grant = 1'b1;
        end
      end
      RQ_WRITE: begin
        if (others != '0) begin
          inv      = 1'b1;
          inv_mask = others;
        end else begin
          upd   = 1'b1;
          nst   = ST_EXC;
          nvec  = sel;
          grant = 1'b1;
          gexcl = 1'b1;
        end
      end
      RQ_WBACK: begin
        if (cur_st == ST_EXC && cur_vec == sel) begin
          upd  = 1'b1;
          nst  = ST_UNC;
          nvec = '0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_pend.sv
module dir_pend #(
  parameter int NPROC = 8,
  parameter int NBLK  = 4,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_fetch,
  input  logic [NPROC-1:0] start_mask,
  input  logic [BLKW-1:0]  start_blk,
  input  logic [PIDW-1:0]  start_src,
  input  logic             ack_valid,
  input  logic [PIDW-1:0]  ack_src,
  output logic             busy,
  output logic             done,
  output logic             d_fetch,
  output logic [NPROC-1:0] d_omask,
  output logic [BLKW-1:0]  d_blk,
  output logic [PIDW-1:0]  d_src
);
  logic [NPROC-1:0] pmask;
  logic [NPROC-1:0] rem;
  logic             ack_hit;

  assign ack_hit = busy && ack_valid && pmask[ack_src];
  assign rem     = pmask & ~(NPROC'(1) << ack_src);
  assign done    = ack_hit && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pmask   <= '0;
      d_fetch <= 1'b0;
      d_omask <= '0;
      d_blk   <= '0;
      d_src   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      pmask   <= start_mask;
      d_fetch <= start_fetch;
      d_omask <= start_mask;
      d_blk   <= start_blk;
      d_src   <= start_src;
    end else if (ack_hit) begin
      pmask <= rem;
      if (rem == '0) busy <= 1'b0;
    end
  end

  // R8
  pend_mask_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pmask != '0));
  // R8
  pend_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack_valid) |=> $stable(pmask));
  // R8
  pend_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int NBLK  = 4,
  localparam int PIDW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BLKW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [PIDW-1:0]  req_src,
  input  logic [BLKW-1:0]  req_blk,
  input  logic             ack_valid,
  input  logic [PIDW-1:0]  ack_src,
  output logic             inv_valid,
  output logic [NPROC-1:0] inv_mask,
  output logic [BLKW-1:0]  inv_blk,
  output logic             fetch_valid,
  output logic [PIDW-1:0]  fetch_dst,
  output logic [BLKW-1:0]  fetch_blk,
  output logic             grant_valid,
  output logic [PIDW-1:0]  grant_dst,
  output logic [BLKW-1:0]  grant_blk,
  output logic             grant_excl
);
  dstate_e          cur_st, nst, wr_state;
  logic [NPROC-1:0] cur_vec, nvec, wr_vec, imask_c, d_omask;
  logic             upd, grant_c, gexcl_c, inv_c, fetch_c;
  logic [PIDW-1:0]  owner_c, d_src;
  logic             busy, done, d_fetch, accept, we;
  logic [BLKW-1:0]  d_blk, wr_blk;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  dir_store #(.NPROC(NPROC), .NBLK(NBLK)) store_i (
    .clk(clk), .rst(rst), .rd_blk(req_blk), .rd_state(cur_st), .rd_vec(cur_vec),
    .we(we), .wr_blk(wr_blk), .wr_state(wr_state), .wr_vec(wr_vec)
  );

  dir_decide #(.NPROC(NPROC)) decide_i (
    .kind(req_kind), .src(req_src), .cur_st(cur_st), .cur_vec(cur_vec),
    .upd(upd), .nst(nst), .nvec(nvec), .grant(grant_c), .gexcl(gexcl_c),
    .inv(inv_c), .inv_mask(imask_c), .fetch(fetch_c), .owner(owner_c)
  );

  dir_pend #(.NPROC(NPROC), .NBLK(NBLK)) pend_i (
    .clk(clk), .rst(rst), .start(accept && (inv_c || fetch_c)),
    .start_fetch(fetch_c), .start_mask(fetch_c ? cur_vec : imask_c),
    .start_blk(req_blk), .start_src(req_src),
    .ack_valid(ack_valid), .ack_src(ack_src),
    .busy(busy), .done(done), .d_fetch(d_fetch), .d_omask(d_omask),
    .d_blk(d_blk), .d_src(d_src)
  );

  always_comb begin
    we       = (accept && upd) || done;
    wr_blk   = done ? d_blk : req_blk;
    wr_state = nst;
    wr_vec   = nvec;
    if (done) begin
      wr_state = d_fetch ? ST_SHR : ST_EXC;
      wr_vec   = (NPROC'(1) << d_src) | (d_fetch ? d_omask : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_valid   <= 1'b0;
      inv_mask    <= '0;
      inv_blk     <= '0;
      fetch_valid <= 1'b0;
      fetch_dst   <= '0;
      fetch_blk   <= '0;
      grant_valid <= 1'b0;
      grant_dst   <= '0;
      grant_blk   <= '0;
      grant_excl  <= 1'b0;
    end else begin
      inv_valid   <= accept && inv_c;
      inv_mask    <= imask_c;
      inv_blk     <= req_blk;
      fetch_valid <= accept && fetch_c;
      fetch_dst   <= owner_c;
      fetch_blk   <= req_blk;
      grant_valid <= (accept && grant_c) || done;
      grant_dst   <= done ? d_src : req_src;
      grant_blk   <= done ? d_blk : req_blk;
      grant_excl  <= done ? !d_fetch : gexcl_c;
    end
  end

  // R4
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_mask != '0));
  // R8
  inv_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);
  // R5
  fetch_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (!req_ready && !grant_valid));
  // R4
  inv_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !grant_valid);
endmodule

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;
  localparam int NP = 8, NB = 4, PW = 3, BW = 2;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_NO = 2'd3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_valid, req_ready, ack_valid;
  logic [1:0] req_kind;
  logic [PW-1:0] req_src, ack_src, fetch_dst, grant_dst;
  logic [BW-1:0] req_blk, inv_blk, fetch_blk, grant_blk;
  logic inv_valid, fetch_valid, grant_valid, grant_excl;
  logic [NP-1:0] inv_mask;

  dir_home_ctrl #(.NPROC(NP), .NBLK(NB)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk),
    .ack_valid(ack_valid), .ack_src(ack_src),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk),
    .fetch_valid(fetch_valid), .fetch_dst(fetch_dst), .fetch_blk(fetch_blk),
    .grant_valid(grant_valid), .grant_dst(grant_dst), .grant_blk(grant_blk),
    .grant_excl(grant_excl)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] expq[$];
  string tagq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_grant(string tag, int d, int b, bit x);
    expq.push_back({26'd0, PW'(d), BW'(b), x});
    tagq.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && grant_valid) begin
      if (expq.size() == 0) chk("R8 unexpected grant", {26'd0, grant_dst, grant_blk, grant_excl}, 0);
      else chk(tagq.pop_front(), {26'd0, grant_dst, grant_blk, grant_excl}, expq.pop_front());
    end
  end

  task automatic send(logic [1:0] k, int s, int b);
    req_valid = 1'b1; req_kind = k; req_src = PW'(s); req_blk = BW'(b);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(int s);
    ack_valid = 1'b1; ack_src = PW'(s);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R8 run hung actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_kind = 0; req_src = 0; req_blk = 0;
    ack_valid = 0; ack_src = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 outputs idle", {grant_valid, inv_valid, fetch_valid}, 0);

    // R1/R3: fresh block, write without invalidation
    expect_grant("R3 excl grant blk3", 5, 3, 1);
    send(K_WR, 5, 3);
    chk("R3 no invalidate", inv_valid, 0);

    // R2: three readers on blk0
    expect_grant("R2 shared grant p1", 1, 0, 0);
    send(K_RD, 1, 0);
    expect_grant("R2 shared grant p2", 2, 0, 0);
    send(K_RD, 2, 0);
    expect_grant("R2 shared grant p4", 4, 0, 0);
    send(K_RD, 4, 0);
    chk("R2 no inv on read", {inv_valid, fetch_valid}, 0);

    // R4: write by p2 invalidates p1 and p4
    expect_grant("R4 excl grant after acks", 2, 0, 1);
    send(K_WR, 2, 0);
    chk("R4 inv valid", inv_valid, 1);
    chk("R4 inv mask", inv_mask, 32'h12);
    chk("R4 inv blk", inv_blk, 0);
    chk("R8 stalled", req_ready, 0);
    ack(4);
    chk("R4 grant withheld", grant_valid, 0);
    ack(6);
    chk("R8 stray ack ignored", {grant_valid, req_ready}, 0);
    // final ack coincides with a waiting read to the same block
    fork
      send(K_RD, 3, 0);
      begin
        ack(1);
        chk("R4 grant after last ack", grant_valid, 1);
        chk("R8 ready back", req_ready, 1);
      end
    join
    // R5: read sees new owner p2
    chk("R5 fetch valid", fetch_valid, 1);
    chk("R5 fetch dst", fetch_dst, 2);
    chk("R5 fetch blk", fetch_blk, 0);
    expect_grant("R5 shared grant after fetch", 3, 0, 0);
    ack(2);
    // R5: holders {2,3}
    expect_grant("R4 excl grant p7", 7, 0, 1);
    send(K_WR, 7, 0);
    chk("R5 both holders invalidated", inv_mask, 32'h0C);
    ack(2);
    ack(3);

    // R9: owner re-read
    expect_grant("R9 owner read excl", 7, 0, 1);
    send(K_RD, 7, 0);
    chk("R9 no fetch", fetch_valid, 0);

    // R7: bogus write-back and null kind are ignored
    send(K_WB, 1, 0);
    chk("R7 wb non-owner silent", {grant_valid, inv_valid, fetch_valid}, 0);
    send(K_NO, 7, 0);
    chk("R7 kind3 silent", {grant_valid, inv_valid, fetch_valid}, 0);
    expect_grant("R7 owner kept, excl to p1", 1, 0, 1);
    send(K_WR, 1, 0);
    chk("R7 owner still p7", inv_mask, 32'h80);
    ack(7);
    send(K_WB, 0, 2);
    expect_grant("R7 blk2 read after stray wb", 0, 2, 0);
    send(K_RD, 0, 2);

    // R6: real write-back empties blk0
    send(K_WB, 1, 0);
    chk("R6 wb silent", grant_valid, 0);
    expect_grant("R6 excl after wb", 6, 0, 1);
    send(K_WR, 6, 0);
    chk("R6 no invalidate", inv_valid, 0);

    // R10: blk3 still owned by p5
    send(K_RD, 0, 3);
    chk("R10 fetch to p5", {fetch_valid, 1'b0, fetch_dst, fetch_blk}, {1'b1, 1'b0, 3'd5, 2'd3});
    ack(4);
    chk("R8 wrong ack on fetch", {grant_valid, req_ready}, 0);
    expect_grant("R10 shared grant blk3", 0, 3, 0);
    ack(5);
    repeat (2) @(negedge clk);
    chk("R2 all grants seen", expq.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule